// File: doc/BRIEF.md
# Display Mask Register with Split Latching

This block is a byte-wide display-control register written by a host CPU. Its bits take effect at different times. The first group is greyscale, blue emphasis, interrupt enable and slave mode. These bits are transparent while the write strobe is high, so they follow the data bus during the write. The second group is rendering enable, red emphasis and green emphasis. These bits are caught in a first-stage latch while the strobe is high. They reach the output only after the strobe falls and the register is deselected. Because of this, the held bits lag the transparent ones by roughly the strobe-high time.

Every output that affects pixel colour is then resampled on the pixel clock. Greyscale and the three emphasis bits pass through one pixel-clock register. Rendering enable passes through the same sample register and then a delay line of `REN_DELAY` further pixel clocks. For this reason, a rendering change shows up `REN_DELAY` pixels later than a greyscale change written at the same time. The interrupt-enable and slave-mode flags do not affect pixels and leave the block straight from the host-side latches. The strobe has no fixed phase relation to the pixel clock.

Top module: `mask_split_reg`

## Requirements
- R1: While `host_wr` is 1, `irq_en` equals `host_data[5]` and `slave_en` equals `host_data[6]`, with no clock edge needed. Greyscale (bit 0) and blue emphasis (bit 4) are transparent in the same way.
- R2: Rendering enable (bit 1), red emphasis (bit 2) and green emphasis (bit 3) do not change at any output while `host_wr` is 1. They take their new value only after `host_wr` falls.
- R3: The held bits take the value that was on `host_data` at the moment `host_wr` fell, not any earlier value seen during the strobe.
- R4: `grey_px` and `emph_px` (bit 0 red, bit 1 green, bit 2 blue) change only at a rising `clk` edge. They show the host-side value that was present at that edge. A bus glitch that spans exactly one edge therefore alters exactly one pixel.
- R5: `render_px` shows the host-side rendering value sampled `REN_DELAY`+1 rising edges earlier. This is `REN_DELAY` edges later than greyscale.
- R6: `host_data[7]` has no effect on any output.
- R7: While `rst` is 1, every output and every internal stage is cleared to 0. `render_px` stays 0 for at least `REN_DELAY` edges after release.
- R8: While `host_wr` is 0, changes on `host_data` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Active-high reset, clears latches and pipeline |
| host_data | input | 8 | Host CPU data byte |
| host_wr | input | 1 | Chip-select/write strobe, active high, asynchronous |
| grey_px | output | 1 | Greyscale, pixel-aligned |
| emph_px | output | 3 | Emphasis {blue, green, red}, pixel-aligned |
| render_px | output | 1 | Rendering enable after the long delay line |
| irq_en | output | 1 | Interrupt-enable flag, direct from host latch |
| slave_en | output | 1 | Slave-mode flag, direct from host latch |

## Verification
The clocked assertions sample the host latches at `clk` edges. They assume that a strobe pulse is wider than one pixel period and that the gap between pulses is also wider than one period. Under that assumption, a strobe that is high or low at two consecutive edges never toggled in between. The bench raises and drops `host_wr` at several phase offsets inside the clock period. It always keeps the pulse and the gap longer than one period. Bus glitches are timed to straddle a single edge, so exactly one sampled pixel can see them.

// File: rtl/mask_pkg.sv
package mask_pkg;
  localparam int MASK_W = 8;

  // bit positions inside the host byte
  localparam int B_GREY   = 0;
  localparam int B_REN    = 1;
  localparam int B_EMPH_R = 2;
  localparam int B_EMPH_G = 3;
  localparam int B_EMPH_B = 4;
  localparam int B_IRQ    = 5;
  localparam int B_SLAVE  = 6;

  // bits transparent while the strobe is high
  localparam logic [MASK_W-1:0] IMM_MASK =
    MASK_W'((1 << B_GREY) | (1 << B_EMPH_B) | (1 << B_IRQ) | (1 << B_SLAVE));
  // bits released only when the strobe falls
  localparam logic [MASK_W-1:0] HELD_MASK =
    MASK_W'((1 << B_REN) | (1 << B_EMPH_R) | (1 << B_EMPH_G));
endpackage

// File: rtl/mask_host_latch.sv
module mask_host_latch
  import mask_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MASK_W-1:0] wr_data,
  input  logic              wr_stb,
  output logic [MASK_W-1:0] imm_q,
  output logic [MASK_W-1:0] held_q
);
  logic [MASK_W-1:0] cap_q;

  // transparent path: follows the bus for the whole strobe
  always_latch begin
    if (rst)         imm_q = '0;
    else if (wr_stb) imm_q = wr_data & IMM_MASK;
  end

  // first stage of the held path: open during the strobe
  always_latch begin
    if (rst)         cap_q = '0;
    else if (wr_stb) cap_q = wr_data & HELD_MASK;
  end

  // second stage: opens on deselection, so it forwards the last strobe value
  always_latch begin
    if (rst)          held_q = '0;
    else if (!wr_stb) held_q = cap_q;
  end

  assert_held_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && $past(wr_stb)) |-> $stable(held_q));

  assert_imm_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (!wr_stb && $past(!wr_stb)) |-> ($stable(imm_q) && $stable(held_q)));

  assert_no_top_bit_R6: assert property (@(posedge clk) disable iff (rst)
    !imm_q[MASK_W-1] && !held_q[MASK_W-1]);
endmodule

// File: rtl/mask_pixel_sync.sv
module mask_pixel_sync #(
  parameter int REN_DELAY = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       grey_in,
  input  logic [2:0] emph_in,
  input  logic       ren_in,
  output logic       grey_px,
  output logic [2:0] emph_px,
  output logic       render_px
);
  localparam int CW = $clog2(REN_DELAY + 2);
  localparam logic [CW-1:0] SAT = CW'(REN_DELAY + 1);

  logic [REN_DELAY:0] ren_pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      grey_px     <= 1'b0;
      emph_px     <= '0;
      ren_pipe[0] <= 1'b0;
    end else begin
      grey_px     <= grey_in;
      emph_px     <= emph_in;
      ren_pipe[0] <= ren_in;
    end
  end

  for (genvar s = 1; s <= REN_DELAY; s++) begin : g_ren_stage
    always_ff @(posedge clk) begin
      if (rst) ren_pipe[s] <= 1'b0;
      else     ren_pipe[s] <= ren_pipe[s-1];
    end
  end

  assign render_px = ren_pipe[REN_DELAY];

  // checker state: edges since reset release, saturating
  logic [CW-1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)               since_rst <= '0;
    else if (since_rst != SAT) since_rst <= since_rst + 1'b1;
  end

  assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!grey_px && emph_px == 3'b000 && !render_px));

  assert_render_late_R5: assert property (@(posedge clk) disable iff (rst)
    (since_rst < CW'(REN_DELAY)) |-> !render_px);
endmodule

// File: rtl/mask_split_reg.sv
module mask_split_reg
  import mask_pkg::*;
#(
  parameter int REN_DELAY = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] host_data,
  input  logic       host_wr,
  output logic       grey_px,
  output logic [2:0] emph_px,
  output logic       render_px,
  output logic       irq_en,
  output logic       slave_en
);
  logic [MASK_W-1:0] imm_q;
  logic [MASK_W-1:0] held_q;

  mask_host_latch u_host (
    .clk    (clk),
    .rst    (rst),
    .wr_data(host_data),
    .wr_stb (host_wr),
    .imm_q  (imm_q),
    .held_q (held_q)
  );

  mask_pixel_sync #(.REN_DELAY(REN_DELAY)) u_pix (
    .clk      (clk),
    .rst      (rst),
    .grey_in  (imm_q[B_GREY]),
    .emph_in  ({imm_q[B_EMPH_B], held_q[B_EMPH_G], held_q[B_EMPH_R]}),
    .ren_in   (held_q[B_REN]),
    .grey_px  (grey_px),
    .emph_px  (emph_px),
    .render_px(render_px)
  );

  assign irq_en   = imm_q[B_IRQ];
  assign slave_en = imm_q[B_SLAVE];

  assert_flags_follow_R1: assert property (@(posedge clk) disable iff (rst)
    host_wr |-> (irq_en == host_data[5] && slave_en == host_data[6]));
endmodule

// File: tb/mask_split_reg_tb.sv
`timescale 1ns/1ps
module mask_split_reg_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] host_data = 8'h00;
  logic       host_wr = 1'b0;
  logic       grey_px, render_px, irq_en, slave_en;
  logic [2:0] emph_px;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mask_split_reg #(.REN_DELAY(4)) u_dut (
    .clk(clk), .rst(rst), .host_data(host_data), .host_wr(host_wr),
    .grey_px(grey_px), .emph_px(emph_px), .render_px(render_px),
    .irq_en(irq_en), .slave_en(slave_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic all_outs(input string req, input logic [6:0] exp);
    chk(req, {slave_en, irq_en, render_px, emph_px, grey_px}, exp);
  endtask

  // R7: reset clears everything even with a strobe active
  task automatic t_reset();
    rst = 1'b1; host_wr = 1'b1; host_data = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    all_outs("R7 reset", 7'd0);
    host_wr = 1'b0; host_data = 8'h00;
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    all_outs("R7 after release", 7'd0);
  endtask

  // R1, R2, R4, R5: full write, immediate vs held vs delayed
  task automatic t_basic();
    @(posedge clk); #3;
    host_data = 8'h7F; host_wr = 1'b1;
    #1;
    chk("R1 irq_en transparent", irq_en, 1);
    chk("R1 slave_en transparent", slave_en, 1);
    @(negedge clk);
    chk("R4 grey before edge", grey_px, 0);
    @(negedge clk);
    chk("R4 grey after edge", grey_px, 1);
    chk("R2 blue early, red/green held", emph_px, 3'b100);
    @(negedge clk);
    chk("R2 red/green still held", emph_px, 3'b100);
    chk("R2 render held", render_px, 0);
    @(posedge clk); #3;
    host_wr = 1'b0;
    #1;
    chk("R8 irq_en kept after strobe", irq_en, 1);
    @(negedge clk);
    chk("R4 held not yet sampled", emph_px, 3'b100);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (k == 1) chk("R2 red/green after release", emph_px, 3'b111);
      if (k == 4) chk("R5 render not yet", render_px, 0);
      if (k == 5) chk("R5 render after delay", render_px, 1);
    end
  endtask

  // R3: held bits take the value present at strobe release
  task automatic t_last_value();
    @(posedge clk); #2;
    host_data = 8'h7F; host_wr = 1'b1;
    @(posedge clk); #2;
    host_data = 8'h01;
    @(posedge clk); #4;
    host_wr = 1'b0;
    host_data = 8'hFF;
    repeat (7) @(negedge clk);
    chk("R3 red/green/blue from last bus value", emph_px, 3'b000);
    chk("R3 render from last bus value", render_px, 0);
    chk("R3 grey", grey_px, 1);
  endtask

  // R8: bus activity with strobe low; R6: top bit ignored
  task automatic t_ignore();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      host_data = (k % 2 == 0) ? 8'hFE : 8'h80;
    end
    repeat (6) @(negedge clk);
    all_outs("R8 bus ignored while deselected", 7'b0000001);
    @(posedge clk); #5;
    host_data = 8'h80; host_wr = 1'b1;
    @(posedge clk); #5;
    host_wr = 1'b0;
    repeat (7) @(negedge clk);
    all_outs("R6 top bit has no effect", 7'd0);
  endtask

  // R4: a glitch spanning one edge alters exactly one pixel
  task automatic t_glitch();
    @(posedge clk); #1;
    host_data = 8'h00; host_wr = 1'b1;
    @(negedge clk); #3;
    host_data = 8'h01;
    @(posedge clk); #2;
    host_data = 8'h00;
    @(negedge clk);
    chk("R4 glitch pixel", grey_px, 1);
    @(negedge clk);
    chk("R4 pixel after glitch", grey_px, 0);
    host_wr = 1'b0;
    repeat (7) @(negedge clk);
  endtask

  // R2: strobe at arbitrary phases; held bits wait for release
  task automatic t_phases();
    logic [1:0] prev = 2'b00;
    for (int off = 1; off <= 9; off++) begin
      logic [1:0] nv = (off % 2 == 1) ? 2'b11 : 2'b00;
      @(posedge clk); #(off);
      host_data = {4'b0000, nv, 2'b00}; host_wr = 1'b1;
      #4;
      chk("R2 phase: held during strobe", emph_px[1:0], prev);
      #13;
      host_wr = 1'b0;
      repeat (2) @(negedge clk);
      chk("R2 phase: visible after release", emph_px[1:0], nv);
      prev = nv;
    end
  endtask

  initial begin
    t_reset();
    t_basic();
    t_last_value();
    t_ignore();
    t_glitch();
    t_phases();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule